// File: doc/BRIEF.md
# Register-Emulated 16550 Host Port

This block lets a local controller pose as a 16550-style serial port on a PC-type host bus. The host sees the usual eight-address register window: receive buffer, transmit holding, interrupt enable, interrupt identification, FIFO control, line control, modem control, line status, modem status and the two divisor latches. No bits are ever shifted onto a wire. Instead, the local CPU pushes received characters into a 16-entry receive FIFO and collects whatever the host writes to the transmit holding register. It also drives the modem status inputs.

Each receive entry stores the data byte together with parity, framing and break flags. The local CPU sets these flags in a shadow register before it pushes the byte, so the host receives line errors exactly as a real UART would report them. Interrupt sources follow the usual 16550 priority order. The host also gets two DMA ready outputs and a receive timeout whose length the local CPU programs.

Top module: `uart_host_mimic`

## Requirements
- R1: After reset, line status reads 0x60, interrupt identification reads 0x01, modem status reads 0x00, h_irq and h_rxrdy are 0, h_txrdy is 1 and l_tx_valid is 0.
- R2: When line control bit 7 is 1, host address 0 reads and writes the divisor low latch and address 1 reads and writes the divisor high latch, and neither access reaches the receive FIFO, the transmit register or the interrupt enable register.
- R3: The receive FIFO returns bytes in push order and holds at most 16 entries in FIFO mode. A push into a full FIFO drops the byte and sets line status bit 1. That bit is cleared by a host read of address 5. A host read of address 0 pops the head, and line status bit 0 is 1 whenever the FIFO holds data.
- R4: Each entry's flags are copied on push from the shadow written via l_flags (bit 0 parity, bit 1 framing, bit 2 break). Line status bits 4:2 show the head entry's flags in that same order, and show 0 when the FIFO is empty.
- R5: In FIFO mode, line status bit 7 is 1 while any stored entry has a nonzero flag, and it returns to 0 once the last such entry has been popped.
- R6: A FIFO control write (address 2) sets FIFO mode with bit 0, clears the receive FIFO with bit 1, empties the transmit register with bit 2, and selects the receive trigger level with bits 7:6 (00=1, 01=4, 10=8, 11=14 bytes). When interrupt enable bit 0 is set, the received-data interrupt (identification code 0x4) is raised once the count reaches the trigger level.
- R7: In FIFO mode, when the FIFO holds at least one byte but fewer than the trigger level, and l_tmo_limit clock cycles pass with no push or pop, a timeout interrupt is raised (code 0xC, enabled by interrupt enable bit 0). It clears on the next pop.
- R8: Interrupt identification bits 3:0 give the highest pending enabled source, in this order: line status 0x6 (enable bit 2), received data 0x4, timeout 0xC, transmit empty 0x2 (enable bit 1), modem status 0x0 (enable bit 3), none 0x1. Bits 7:6 read 11 in FIFO mode and 00 otherwise. h_irq is 1 exactly when a source is pending.
- R9: While l_mode450 is 1, a FIFO control write cannot enable FIFO mode. The receive path then holds a single byte, so a second push overruns, and line status bit 7 and identification bits 7:6 read 0.
- R10: The modem status register reads {dcd, ri, dsr, cts} in bits 7:4 from l_msr[3:0], as last written by the local CPU. Bits 3:0 hold change flags: a change in carrier, a falling ring indicator, a change in data set ready, and a change in clear to send. A host read of address 6 clears these flags.
- R11: A host write to address 0 fills the transmit register. That drops h_txrdy, clears line status bits 6:5 and raises l_tx_valid with the byte on l_tx_data. An l_tx_pop empties the register and arms the transmit-empty interrupt. Arming also happens when interrupt enable bit 1 is set while the register is empty. A host write to address 0, or a read of the identification register that reports this interrupt, disarms it.
- R12: h_rxrdy is 1 whenever the receive FIFO holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_cs | input | 1 | Host chip select |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for the addressed register |
| h_irq | output | 1 | Host interrupt request |
| h_rxrdy | output | 1 | Receive DMA ready |
| h_txrdy | output | 1 | Transmit DMA ready |
| l_mode450 | input | 1 | Local force of non-FIFO mode |
| l_flags_we | input | 1 | Load the error-flag shadow |
| l_flags | input | 3 | Shadow flags {break, framing, parity} |
| l_push | input | 1 | Push l_pdata into the receive FIFO |
| l_pdata | input | 8 | Received byte from the local CPU |
| l_tx_pop | input | 1 | Local CPU takes the transmit byte |
| l_tx_valid | output | 1 | Transmit register holds a byte |
| l_tx_data | output | 8 | Byte written by the host |
| l_msr_we | input | 1 | Load the modem status inputs |
| l_msr | input | 4 | {dcd, ri, dsr, cts} |
| l_tmo_limit | input | 8 | Receive timeout length in clock cycles |

## Verification
The bench runs through all four trigger levels and checks the identification register after every push. A design with an off-by-one threshold would raise the interrupt one byte early or one byte late. It fills the FIFO to 16 entries and then pushes one more byte, so a design that wraps its pointers would overwrite the oldest byte instead of dropping the new one and flagging overrun. It then drains the FIFO and computes, at each step, whether any flagged entry is still inside. A design that clears bit 7 after the first flagged pop, or that reports the tail's flags instead of the head's, gives the wrong line status there. The bench also checks the timeout interrupt, line status winning over received data, change flags that clear on read, and the single-entry behaviour in 16450 mode.

// File: rtl/uart_host_mimic.sv
module uart_host_mimic #(
  parameter int DEPTH = 16,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_cs,
  input  logic             h_rd,
  input  logic             h_wr,
  input  logic [2:0]       h_addr,
  input  logic [7:0]       h_wdata,
  output logic [7:0]       h_rdata,
  output logic             h_irq,
  output logic             h_rxrdy,
  output logic             h_txrdy,
  input  logic             l_mode450,
  input  logic             l_flags_we,
  input  logic [2:0]       l_flags,
  input  logic             l_push,
  input  logic [7:0]       l_pdata,
  input  logic             l_tx_pop,
  output logic             l_tx_valid,
  output logic [7:0]       l_tx_data,
  input  logic             l_msr_we,
  input  logic [3:0]       l_msr,
  input  logic [TMO_W-1:0] l_tmo_limit
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [10:0]      mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, errcnt, cap, lvl;
  logic [TMO_W-1:0] tcnt;
  logic [7:0]       dll, dlm, lcr, mcr, thr;
  logic [3:0]       ier, msr_s, msr_d, id;
  logic [2:0]       shadow;
  logic [1:0]       trig;
  logic             fcr_en, oe, thr_full, thre_pend;

  wire rd_s      = h_cs & h_rd;
  wire wr_s      = h_cs & h_wr;
  wire dlab      = lcr[7];
  wire fifo_mode = fcr_en & ~l_mode450;
  wire fcr_wr    = wr_s && h_addr == 3'd2;
  wire new_en    = h_wdata[0] & ~l_mode450;
  wire clr       = fcr_wr && (h_wdata[1] || new_en != fcr_en);
  wire pop       = rd_s && h_addr == 3'd0 && !dlab && cnt != '0;
  wire push_ok   = l_push && cnt < cap;
  wire thr_wr    = wr_s && h_addr == 3'd0 && !dlab;
  wire [10:0] head = mem[rp];
  wire [2:0] hflg  = (cnt != '0) ? head[10:8] : 3'b000;

  assign cap = fifo_mode ? CW'(DEPTH) : CW'(1);
  always_comb
    case (trig)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(4);
      2'd2:    lvl = CW'(8);
      default: lvl = CW'(14);
    endcase

  wire ls  = oe | (|hflg);
  wire rda = cnt != '0 && (!fifo_mode || cnt >= lvl);
  wire tmo = fifo_mode && cnt != '0 && cnt < lvl && tcnt == l_tmo_limit;

  always_comb
    if (ier[2] && ls)               id = 4'h6;
    else if (ier[0] && rda)         id = 4'h4;
    else if (ier[0] && tmo)         id = 4'hC;
    else if (ier[1] && thre_pend)   id = 4'h2;
    else if (ier[3] && msr_d != '0) id = 4'h0;
    else                            id = 4'h1;

  wire [7:0] iir = {fifo_mode, fifo_mode, 2'b00, id};
  wire [7:0] lsr = {fifo_mode && errcnt != '0, ~thr_full, ~thr_full, hflg, oe, cnt != '0};

  always_comb
    case (h_addr)
      3'd0:    h_rdata = dlab ? dll : head[7:0];
      3'd1:    h_rdata = dlab ? dlm : {4'b0, ier};
      3'd2:    h_rdata = iir;
      3'd3:    h_rdata = lcr;
      3'd4:    h_rdata = mcr;
      3'd5:    h_rdata = lsr;
      3'd6:    h_rdata = {msr_s, msr_d};
      default: h_rdata = 8'h00;
    endcase

  assign h_irq      = ~id[0];
  assign h_rxrdy    = cnt != '0;
  assign h_txrdy    = ~thr_full;
  assign l_tx_valid = thr_full;
  assign l_tx_data  = thr;

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= {shadow, l_pdata};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; errcnt <= '0; tcnt <= '0; oe <= 1'b0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0; errcnt <= '0; tcnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt    <= cnt + CW'(push_ok) - CW'(pop);
      errcnt <= errcnt + CW'(push_ok && shadow != '0) - CW'(pop && head[10:8] != '0);
      if (push_ok || pop || cnt == '0) tcnt <= '0;
      else if (tcnt != l_tmo_limit)    tcnt <= tcnt + 1'b1;
      if (l_push && !push_ok)              oe <= 1'b1;
      else if (rd_s && h_addr == 3'd5)     oe <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dll <= '0; dlm <= '0; lcr <= '0; mcr <= '0; ier <= '0; trig <= '0;
      fcr_en <= 1'b0; shadow <= '0; msr_s <= '0; msr_d <= '0;
      thr <= '0; thr_full <= 1'b0; thre_pend <= 1'b0;
    end else begin
      if (wr_s && h_addr == 3'd0 && dlab)  dll <= h_wdata;
      if (wr_s && h_addr == 3'd1 && dlab)  dlm <= h_wdata;
      if (wr_s && h_addr == 3'd1 && !dlab) ier <= h_wdata[3:0];
      if (wr_s && h_addr == 3'd3)          lcr <= h_wdata;
      if (wr_s && h_addr == 3'd4)          mcr <= {3'b000, h_wdata[4:0]};
      if (fcr_wr) begin
        fcr_en <= new_en;
        trig   <= h_wdata[7:6];
      end
      if (l_flags_we) shadow <= l_flags;
      if (l_msr_we) msr_s <= l_msr;
      msr_d <= ((rd_s && h_addr == 3'd6) ? 4'b0 : msr_d)
             | (l_msr_we ? {msr_s[3] ^ l_msr[3], msr_s[2] & ~l_msr[2],
                            msr_s[1] ^ l_msr[1], msr_s[0] ^ l_msr[0]} : 4'b0);
      if (thr_wr) begin
        thr <= h_wdata;
        thr_full <= 1'b1;
      end else if (l_tx_pop || (fcr_wr && h_wdata[2])) thr_full <= 1'b0;
      if (thr_wr)
        thre_pend <= 1'b0;
      else if ((l_tx_pop && thr_full) ||
               (wr_s && h_addr == 3'd1 && !dlab && h_wdata[1] && !ier[1] && !thr_full))
        thre_pend <= 1'b1;
      else if (rd_s && h_addr == 3'd2 && id == 4'h2)
        thre_pend <= 1'b0;
    end
endmodule

// File: rtl/uart_host_mimic_chk.sv
module uart_host_mimic_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_cs,
  input logic          h_rd,
  input logic          h_wr,
  input logic [2:0]    h_addr,
  input logic [7:0]    h_rdata,
  input logic          h_irq,
  input logic          h_rxrdy,
  input logic          h_txrdy,
  input logic          l_mode450,
  input logic          l_push,
  input logic          l_tx_pop,
  input logic          l_tx_valid,
  input logic [CW-1:0] cnt,
  input logic          oe,
  input logic          dlab,
  input logic [3:0]    ier
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_oe_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_cs && h_rd && h_addr == 3'd5 && !l_push |=> !oe);

  assert_rxrdy_after_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
    l_push && !h_rxrdy && !(h_cs && h_wr && h_addr == 3'd2) |=> h_rxrdy);

  assert_thr_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    h_cs && h_wr && h_addr == 3'd0 && !dlab |=> !h_txrdy && l_tx_valid);

  assert_legacy_lsr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    l_mode450 && h_addr == 3'd5 |-> !h_rdata[7]);

  assert_legacy_iir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    l_mode450 && h_addr == 3'd2 |-> h_rdata[7:6] == 2'b00);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ier == 4'h0 |-> !h_irq);

  assert_tx_pop_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    l_tx_pop && !(h_cs && h_wr && h_addr == 3'd0 && !dlab) |=> h_txrdy);
endmodule

bind uart_host_mimic uart_host_mimic_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
  .h_rdata(h_rdata), .h_irq(h_irq), .h_rxrdy(h_rxrdy), .h_txrdy(h_txrdy),
  .l_mode450(l_mode450), .l_push(l_push), .l_tx_pop(l_tx_pop), .l_tx_valid(l_tx_valid),
  .cnt(cnt), .oe(oe), .dlab(lcr[7]), .ier(ier));

// File: tb/uart_host_mimic_bench.sv
module uart_host_mimic_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_cs = 0, h_rd = 0, h_wr = 0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic h_irq, h_rxrdy, h_txrdy;
  logic l_mode450 = 0, l_flags_we = 0, l_push = 0, l_tx_pop = 0, l_msr_we = 0;
  logic [2:0] l_flags = '0;
  logic [7:0] l_pdata = '0, l_tx_data;
  logic l_tx_valid;
  logic [3:0] l_msr = '0;
  logic [7:0] l_tmo_limit = 8'd40;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_host_mimic u_uart_host_mimic (
    .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .h_rxrdy(h_rxrdy),
    .h_txrdy(h_txrdy), .l_mode450(l_mode450), .l_flags_we(l_flags_we), .l_flags(l_flags),
    .l_push(l_push), .l_pdata(l_pdata), .l_tx_pop(l_tx_pop), .l_tx_valid(l_tx_valid),
    .l_tx_data(l_tx_data), .l_msr_we(l_msr_we), .l_msr(l_msr), .l_tmo_limit(l_tmo_limit));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); h_cs = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_cs = 0; h_wr = 0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); h_cs = 1; h_rd = 1; h_addr = a;
    #1 d = h_rdata;
    @(negedge clk); h_cs = 0; h_rd = 0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    @(negedge clk); l_flags_we = 1; l_flags = f;
    @(negedge clk); l_flags_we = 0; l_push = 1; l_pdata = d;
    @(negedge clk); l_push = 0;
  endtask

  task automatic msr_set(input logic [3:0] m);
    @(negedge clk); l_msr_we = 1; l_msr = m;
    @(negedge clk); l_msr_we = 0;
  endtask

  function automatic logic [2:0] fpat(input int i);
    return (i % 3 == 0) ? 3'(i) : 3'b000;
  endfunction

  function automatic logic rem_flagged(input int from);
    logic r = 0;
    for (int j = from; j < 16; j++) r |= (fpat(j) != 0);
    return r;
  endfunction

  initial begin
    logic [7:0] v;
    int lv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    hr(5, v); chk("R1 lsr", v, 8'h60);
    hr(2, v); chk("R1 iir", v, 8'h01);
    hr(6, v); chk("R1 msr", v, 8'h00);
    chk("R1 pins", {h_irq, h_rxrdy, h_txrdy, l_tx_valid}, 8'h02);

    // R2 divisor latches
    hw(3, 8'h80); hw(0, 8'h34); hw(1, 8'h12);
    hr(0, v); chk("R2 dll", v, 8'h34);
    hr(1, v); chk("R2 dlm", v, 8'h12);
    chk("R2 no thr", {7'b0, h_txrdy}, 8'h01);
    hw(3, 8'h03);
    hr(1, v); chk("R2 ier untouched", v, 8'h00);
    hr(5, v); chk("R2 fifo untouched", v, 8'h60);

    // R3 R4 R5 R12 fill, overrun, drain
    hw(2, 8'h07);
    for (int i = 0; i < 16; i++) push(8'(i + 16), fpat(i));
    chk("R12 rxrdy", {7'b0, h_rxrdy}, 8'h01);
    push(8'hEE, 3'b000);
    hr(5, v); chk("R3 overrun", v, 8'hE3);
    hr(5, v); chk("R3 overrun cleared", v, 8'hE1);
    for (int i = 0; i < 16; i++) begin
      hr(5, v); chk("R4 R5 lsr head", v, {rem_flagged(i), 2'b11, fpat(i), 2'b01});
      hr(0, v); chk("R3 order", v, 8'(i + 16));
    end
    hr(5, v); chk("R5 drained", v, 8'h60);
    chk("R12 rxrdy empty", {7'b0, h_rxrdy}, 8'h00);

    // R6 R7 R8 trigger sweep and timeout
    for (int t = 0; t < 4; t++) begin
      lv = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
      hw(2, {2'(t), 6'b000011});
      hw(1, 8'h01);
      for (int k = 1; k <= lv; k++) begin
        push(8'(k), 3'b000);
        hr(2, v); chk("R6 trigger", v, (k >= lv) ? 8'hC4 : 8'hC1);
        chk("R8 irq pin", {7'b0, h_irq}, (k >= lv) ? 8'h01 : 8'h00);
      end
      for (int k = 1; k <= lv; k++) begin
        hr(0, v); chk("R6 drain", v, 8'(k));
      end
      hr(2, v); chk("R6 empty", v, 8'hC1);
      if (lv > 1) begin
        push(8'h77, 3'b000);
        hr(2, v); chk("R7 not yet", v, 8'hC1);
        repeat (42) @(negedge clk);
        hr(2, v); chk("R7 timeout", v, 8'hCC);
        hr(0, v); chk("R7 data", v, 8'h77);
        hr(2, v); chk("R7 cleared", v, 8'hC1);
      end
    end

    // R8 line status outranks received data
    hw(2, 8'h03); hw(1, 8'h05);
    push(8'h55, 3'b100);
    hr(2, v); chk("R8 priority", v, 8'hC6);
    hr(0, v); chk("R8 data", v, 8'h55);
    hr(2, v); chk("R8 none", v, 8'hC1);
    hw(1, 8'h00);

    // R9 16450 mode
    l_mode450 = 1;
    hw(2, 8'h07);
    hr(2, v); chk("R9 iir", v, 8'h01);
    push(8'hA1, 3'b011);
    hr(5, v); chk("R9 lsr", v, 8'h6D);
    push(8'hA2, 3'b000);
    hr(5, v); chk("R9 single entry overrun", v, 8'h6F);
    hr(0, v); chk("R9 data", v, 8'hA1);
    hr(5, v); chk("R9 empty", v, 8'h60);
    l_mode450 = 0;
    hw(2, 8'h01);

    // R10 modem status
    hw(1, 8'h08);
    msr_set(4'b1011);
    hr(2, v); chk("R10 irq", v, 8'hC0);
    hr(6, v); chk("R10 msr", v, 8'hBB);
    hr(6, v); chk("R10 deltas cleared", v, 8'hB0);
    hr(2, v); chk("R10 no irq", v, 8'hC1);
    msr_set(4'b1111);
    hr(6, v); chk("R10 ri rising", v, 8'hF0);
    msr_set(4'b1011);
    hr(6, v); chk("R10 ri trailing", v, 8'hB4);
    hw(1, 8'h00);

    // R11 transmit path
    hw(1, 8'h02);
    hr(2, v); chk("R11 armed", v, 8'hC2);
    hw(0, 8'h5A);
    chk("R11 txrdy", {7'b0, h_txrdy}, 8'h00);
    chk("R11 tx byte", l_tx_valid ? l_tx_data : 8'hFF, 8'h5A);
    hr(5, v); chk("R11 lsr full", v, 8'h00);
    hr(2, v); chk("R11 disarmed", v, 8'hC1);
    @(negedge clk); l_tx_pop = 1;
    @(negedge clk); l_tx_pop = 0;
    chk("R11 txrdy back", {7'b0, h_txrdy}, 8'h01);
    hr(2, v); chk("R11 thre irq", v, 8'hC2);
    hr(2, v); chk("R11 iir read clears", v, 8'hC1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule